// File: doc/BRIEF.md
# Serial Bit-Pattern Trigger

This block watches a 16-lane logic word and picks one lane as a sampling clock. It also picks one data bit, which is either a single lane or a logical combination of several lanes. Each time the clock lane shows the selected kind of transition, the block takes one data bit and shifts it into a history register. The newest bit always sits at bit 0.

The history is compared against a programmed pattern of up to 32 bits. The pattern is written as a value word plus a care word, so each position can demand a one, demand a zero, or accept either. Only the lowest `pat_len` positions take part in the comparison. When they all agree, the block raises a single-cycle trigger. Matches may overlap, so a long run of matching samples fires on every sampling edge.

All inputs are sampled in the block's own clock domain. A clock-lane transition is seen by comparing two successive samples of that lane.

Top module: `bitseq_trigger`

## Requirements
- R1: While `rst` is high, and in the cycles after it falls, `trig` stays 0. Reset empties the history, so a fresh fill of `pat_len` samples is needed before any trigger.
- R2: `clk_sel` picks the clock lane. `edge_sel` takes one of four codes: 0 means never sample, 1 means sample on a low-to-high change, 2 on a high-to-low change, and 3 on either change. A change is a difference between two consecutive samples of the selected lane.
- R3: `data_mode` sets the data bit. With 0 it is lane `data_sel`. For the other codes, each lane is first XORed with its `comb_inv` bit and then restricted to the lanes set in `comb_mask`. Code 1 ANDs those lanes (an empty mask gives 1), code 2 ORs them, and code 3 XORs them.
- R4: On each sampling edge the history shifts up by one and the new data bit enters at bit 0. History bit i is compared with bit i of `pat_val` and `pat_care`.
- R5: A history position whose `pat_care` bit is 0 always agrees. A position whose care bit is 1 agrees only when it equals the `pat_val` bit.
- R6: Only positions 0 to `pat_len`-1 are compared. A `pat_len` of 0 never triggers, and a value above 32 acts as 32.
- R7: No trigger fires until at least `pat_len` samples have been shifted in since the last reset or since `en` last rose.
- R8: A matching sample gives exactly one `trig` cycle. `trig` is high in the fourth clock cycle of the lane word that holds the sampling edge, counting that word's own cycle as the first. Overlapping matches fire on consecutive sampling edges.
- R9: While `en` is low the history is cleared and `trig` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables sampling and triggering; low clears the history |
| lanes | input | 16 | Sampled logic lanes |
| clk_sel | input | 4 | Index of the lane used as the sampling clock |
| data_sel | input | 4 | Index of the data lane in single-lane mode |
| data_mode | input | 2 | Data source: 0 lane, 1 AND, 2 OR, 3 XOR |
| comb_mask | input | 16 | Lanes that take part in a combined data source |
| comb_inv | input | 16 | Per-lane inversion applied before combining |
| edge_sel | input | 2 | 0 none, 1 rising, 2 falling, 3 either |
| pat_val | input | 32 | Required bit values; bit 0 is the newest sample |
| pat_care | input | 32 | 1 marks a position as compared, 0 as don't-care |
| pat_len | input | 6 | Number of compared positions, 0 to 32 |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The assertions check on every cycle that the newest data bit enters at bit 0 while the older bits move up, and that a sampling edge is only ever produced by a real change in the clock lane of the chosen direction. They also check that a low `en` empties the history and silences `trig`, and that a trigger only follows a history update, with a non-zero length and a non-empty history. Only the bench's scenarios can show that the whole comparison gives the right answer: don't-care positions, the length window and its clamp, the fill rule, each data combination, and the exact cycle and count of trigger pulses for overlapping matches. They also show that a reset or a disable in the middle of a stream restarts the fill.

// File: rtl/bitseq_pkg.sv
package bitseq_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_e;

  typedef enum logic [1:0] {
    SRC_LANE = 2'd0,
    SRC_AND  = 2'd1,
    SRC_OR   = 2'd2,
    SRC_XOR  = 2'd3
  } src_e;

endpackage

// File: rtl/bitseq_source.sv
module bitseq_source
  import bitseq_pkg::*;
#(
  parameter int NCH = 16,
  localparam int SELW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  lanes,
  input  logic [SELW-1:0] clk_sel,
  input  logic [SELW-1:0] data_sel,
  input  logic [1:0]      data_mode,
  input  logic [NCH-1:0]  comb_mask,
  input  logic [NCH-1:0]  comb_inv,
  input  logic [1:0]      edge_sel,
  output logic            shift_q,
  output logic            bit_q
);

  logic [NCH-1:0] lanes_q;
  logic [NCH-1:0] term;
  logic           ck_prev;
  logic           ck_now;
  logic           edge_hit;
  logic           and_v;
  logic           or_v;
  logic           xor_v;
  logic           data_bit;

  // per-lane polarity before combining
  for (genvar g = 0; g < NCH; g++) begin : g_term
    assign term[g] = lanes_q[g] ^ comb_inv[g];
  end

  assign and_v  = &(term | ~comb_mask);
  assign or_v   = |(term & comb_mask);
  assign xor_v  = ^(term & comb_mask);
  assign ck_now = lanes_q[clk_sel];

  always_comb begin
    case (edge_e'(edge_sel))
      EDGE_NONE: edge_hit = 1'b0;
      EDGE_RISE: edge_hit = ~ck_prev & ck_now;
      EDGE_FALL: edge_hit = ck_prev & ~ck_now;
      default:   edge_hit = ck_prev ^ ck_now;
    endcase
  end

  always_comb begin
    case (src_e'(data_mode))
      SRC_LANE: data_bit = lanes_q[data_sel];
      SRC_AND:  data_bit = and_v;
      SRC_OR:   data_bit = or_v;
      default:  data_bit = xor_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lanes_q <= '0;
      ck_prev <= 1'b0;
      shift_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      lanes_q <= lanes;
      ck_prev <= ck_now;
      shift_q <= edge_hit;
      bit_q   <= data_bit;
    end
  end

  AST_EDGE_IS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    shift_q |-> $past(ck_now != ck_prev)); // R2

  AST_RISE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    (shift_q && $past(edge_sel) == 2'd1) |-> ($past(ck_now) && !$past(ck_prev))); // R2

  AST_NONE_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(edge_sel) == 2'd0) |-> !shift_q); // R2

endmodule

// File: rtl/bitseq_history.sv
module bitseq_history #(
  parameter int PW = 32,
  localparam int LENW = $clog2(PW) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            shift,
  input  logic            din,
  output logic [PW-1:0]   hist,
  output logic [LENW-1:0] fill,
  output logic            upd
);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hist <= '0;
      fill <= '0;
      upd  <= 1'b0;
    end else begin
      upd <= shift;
      if (shift) begin
        hist <= {hist[PW-2:0], din};
        if (fill != LENW'(PW)) fill <= fill + LENW'(1);
      end
    end
  end

  AST_NEWEST_AT_LSB: assert property (@(posedge clk) disable iff (rst)
    (en && shift) |=> (hist[0] == $past(din))); // R4

  AST_OLDER_MOVE_UP: assert property (@(posedge clk) disable iff (rst)
    (en && shift) |=> (hist[PW-1:1] == $past(hist[PW-2:0]))); // R4

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (fill == '0 && hist == '0 && !upd)); // R9

endmodule

// File: rtl/bitseq_match.sv
module bitseq_match #(
  parameter int PW = 32,
  localparam int LENW = $clog2(PW) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PW-1:0]   hist,
  input  logic [LENW-1:0] fill,
  input  logic            upd,
  input  logic [PW-1:0]   pat_val,
  input  logic [PW-1:0]   pat_care,
  input  logic [LENW-1:0] pat_len,
  output logic            trig
);

  logic [LENW-1:0] len_eff;
  logic [PW-1:0]   lmask;
  logic            filled;
  logic            hit;

  assign len_eff = (pat_len > LENW'(PW)) ? LENW'(PW) : pat_len;

  // window of compared positions
  for (genvar g = 0; g < PW; g++) begin : g_lmask
    assign lmask[g] = (len_eff > LENW'(g));
  end

  assign filled = (fill >= len_eff);
  assign hit    = (len_eff != '0) && filled &&
                  (((hist ^ pat_val) & pat_care & lmask) == '0);

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= en & upd & hit;
  end

  AST_TRIG_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst)
    trig |-> $past(upd)); // R8

  AST_LEN_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    trig |-> ($past(pat_len) != '0)); // R6

  AST_TRIG_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
    trig |-> ($past(fill) != '0)); // R7

endmodule

// File: rtl/bitseq_trigger.sv
module bitseq_trigger #(
  parameter int NCH = 16,
  parameter int PW = 32,
  localparam int SELW = $clog2(NCH),
  localparam int LENW = $clog2(PW) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [NCH-1:0]  lanes,
  input  logic [SELW-1:0] clk_sel,
  input  logic [SELW-1:0] data_sel,
  input  logic [1:0]      data_mode,
  input  logic [NCH-1:0]  comb_mask,
  input  logic [NCH-1:0]  comb_inv,
  input  logic [1:0]      edge_sel,
  input  logic [PW-1:0]   pat_val,
  input  logic [PW-1:0]   pat_care,
  input  logic [LENW-1:0] pat_len,
  output logic            trig
);

  logic            shift_q;
  logic            bit_q;
  logic [PW-1:0]   hist;
  logic [LENW-1:0] fill;
  logic            upd;

  bitseq_source #(.NCH(NCH)) u_source (
    .clk       (clk),
    .rst       (rst),
    .lanes     (lanes),
    .clk_sel   (clk_sel),
    .data_sel  (data_sel),
    .data_mode (data_mode),
    .comb_mask (comb_mask),
    .comb_inv  (comb_inv),
    .edge_sel  (edge_sel),
    .shift_q   (shift_q),
    .bit_q     (bit_q)
  );

  bitseq_history #(.PW(PW)) u_history (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .shift (shift_q),
    .din   (bit_q),
    .hist  (hist),
    .fill  (fill),
    .upd   (upd)
  );

  bitseq_match #(.PW(PW)) u_match (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .hist     (hist),
    .fill     (fill),
    .upd      (upd),
    .pat_val  (pat_val),
    .pat_care (pat_care),
    .pat_len  (pat_len),
    .trig     (trig)
  );

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !trig); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !trig); // R1

endmodule

// File: tb/bitseq_trigger_tb.sv
module bitseq_trigger_tb;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  edg;
    logic [31:0] val;
    logic [31:0] care;
    logic [5:0]  len;
    logic [31:0] dbits;
  } vec_t;

  // mode: 0 lane,1 AND,2 OR,3 XOR ; edg: 0 none,1 rise,2 fall,3 either
  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 2'd1, 32'h0000000B, 32'h0000000F, 6'd4,  32'hDEADBEEF},
    '{2'd0, 2'd2, 32'h00000005, 32'h00000007, 6'd3,  32'h5A5AC3C3},
    '{2'd0, 2'd3, 32'h00000001, 32'h00000001, 6'd1,  32'hFFFF00F0},
    '{2'd1, 2'd1, 32'h00000003, 32'h00000003, 6'd2,  32'hF0F0FFFF},
    '{2'd2, 2'd3, 32'h00000006, 32'h0000000F, 6'd4,  32'h12345678},
    '{2'd3, 2'd3, 32'h00000005, 32'h0000000D, 6'd4,  32'hA5A5A5A5},
    '{2'd0, 2'd1, 32'h00000000, 32'h00000000, 6'd5,  32'h00000000},
    '{2'd0, 2'd3, 32'h00000000, 32'h00000000, 6'd0,  32'h00000003},
    '{2'd0, 2'd3, 32'h55555555, 32'hFFFFFFFF, 6'd45, 32'hAAAAAAAA},
    '{2'd0, 2'd0, 32'h00000000, 32'h00000000, 6'd1,  32'hFFFFFFFF},
    '{2'd0, 2'd3, 32'h12345678, 32'h00000000, 6'd32, 32'h00000000}
  };

  function automatic string vec_req(input int k);
    case (k)
      0: return "R4";
      1: return "R2";
      2: return "R8";
      3: return "R3";
      4: return "R3";
      5: return "R5";
      6: return "R7";
      7: return "R6";
      8: return "R6";
      9: return "R2";
      default: return "R7";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] lanes = '0;
  logic [3:0]  clk_sel = 4'd2;
  logic [3:0]  data_sel = 4'd5;
  logic [1:0]  data_mode = 2'd0;
  logic [15:0] comb_mask = 16'h0220;
  logic [15:0] comb_inv = 16'h0200;
  logic [1:0]  edge_sel = 2'd0;
  logic [31:0] pat_val = '0;
  logic [31:0] pat_care = '0;
  logic [5:0]  pat_len = '0;
  logic        trig;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] mh = '0;
  int          mfill = 0;
  logic        prevclk = 1'b0;
  int          ck_lane = 2;

  always #5 clk = ~clk;

  bitseq_trigger u_dut (
    .clk(clk), .rst(rst), .en(en), .lanes(lanes), .clk_sel(clk_sel),
    .data_sel(data_sel), .data_mode(data_mode), .comb_mask(comb_mask),
    .comb_inv(comb_inv), .edge_sel(edge_sel), .pat_val(pat_val),
    .pat_care(pat_care), .pat_len(pat_len), .trig(trig)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    mh = '0;
    mfill = 0;
  endtask

  // one lane word held for 4 cycles; called and returns at a negedge
  task automatic do_phase(input logic d, input logic ck, input logic l9,
                          input string req);
    logic t9, db, edge_ev, fire;
    logic [31:0] lm;
    int le, hits, pos;
    lanes = '0;
    lanes[ck_lane] = ck;
    lanes[5] = d;
    lanes[9] = l9;
    t9 = ~l9;
    case (data_mode)
      2'd0: db = d;
      2'd1: db = d & t9;
      2'd2: db = d | t9;
      default: db = d ^ t9;
    endcase
    case (edge_sel)
      2'd0: edge_ev = 1'b0;
      2'd1: edge_ev = !prevclk && ck;
      2'd2: edge_ev = prevclk && !ck;
      default: edge_ev = prevclk != ck;
    endcase
    prevclk = ck;
    le = (int'(pat_len) > 32) ? 32 : int'(pat_len);
    lm = (le >= 32) ? 32'hFFFFFFFF : ((32'h1 << le) - 32'h1);
    fire = 1'b0;
    if (!en) model_clear();
    else if (edge_ev) begin
      mh = {mh[30:0], db};
      if (mfill < 32) mfill++;
      fire = (le != 0) && (mfill >= le) && (((mh ^ pat_val) & pat_care & lm) == '0);
    end
    hits = 0;
    pos = -1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      if (trig) begin hits++; pos = j; end
    end
    check(hits == (fire ? 1 : 0), req, "trigger count", hits, fire ? 1 : 0);
    if (fire) check(pos == 3, "R8", "trigger cycle", pos, 3);
  endtask

  task automatic idle(input int n);
    en = 1'b0;
    lanes = '0;
    prevclk = 1'b0;
    model_clear();
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    lanes = 16'hFFFF;
    repeat (3) begin
      @(negedge clk);
      lanes = ~lanes;
      check(trig == 1'b0, "R1", "trig during reset", int'(trig), 0);
    end
    lanes = '0;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(trig == 1'b0, "R1", "trig after reset", int'(trig), 0);
    end

    // vector table
    for (int k = 0; k < NV; k++) begin
      idle(1);
      data_mode = VECS[k].mode;
      edge_sel  = VECS[k].edg;
      pat_val   = VECS[k].val;
      pat_care  = VECS[k].care;
      pat_len   = VECS[k].len;
      idle(4);
      en = 1'b1;
      for (int i = 0; i < 32; i++)
        do_phase(VECS[k].dbits[i], (k == 8) ? ~i[0] : i[0], i[1], vec_req(k));
    end

    // R1: reset mid-stream restarts the fill
    idle(4);
    data_mode = 2'd0; edge_sel = 2'd1;
    pat_val = '0; pat_care = '0; pat_len = 6'd3;
    en = 1'b1;
    for (int i = 0; i < 4; i++) do_phase(1'b1, i[0], 1'b0, "R1");
    rst = 1'b1;
    model_clear();
    repeat (2) begin
      @(negedge clk);
      check(trig == 1'b0, "R1", "trig in mid reset", int'(trig), 0);
    end
    rst = 1'b0;
    for (int i = 4; i < 12; i++) do_phase(1'b1, i[0], 1'b0, "R1");

    // R9: disable mid-stream clears and silences
    idle(4);
    en = 1'b1;
    for (int i = 0; i < 6; i++) do_phase(1'b0, i[0], 1'b0, "R9");
    en = 1'b0;
    for (int i = 6; i < 10; i++) do_phase(1'b1, i[0], 1'b0, "R9");
    en = 1'b1;
    for (int i = 10; i < 18; i++) do_phase(1'b1, i[0], 1'b0, "R9");

    // R2: other clock lane, old lane held still
    idle(4);
    ck_lane = 11; clk_sel = 4'd11;
    edge_sel = 2'd1; pat_val = 32'h1; pat_care = 32'h1; pat_len = 6'd1;
    idle(2);
    en = 1'b1;
    for (int i = 0; i < 12; i++) do_phase(i[2], i[0], 1'b0, "R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule